// File: doc/BRIEF.md
# CPU and Peripheral Clock Stop Sequencer

This block sits between a clock generator's free-running output phases and its output pins. It runs in a fast sampling-clock domain. The source phases (a CPU phase, the free-running PCI phase, the 66 MHz buffer phase and a set of other single-ended phases) arrive as levels that are synchronous to that clock. The block passes each phase to its output, one sampling cycle later, until a low-power request arrives. It then gates the outputs without producing a runt pulse.

Two active-low requests drive it. The power-down request is synchronised and only counts once it has been seen low at two consecutive rising edges of the CPU complement clock. It then halts the single-ended outputs in a fixed order: the free-running PCI output first, the buffer output next, and then the rest, each stopping low. The CPU pairs park with the true output high. When everything has stopped, a core-off flag tells the generator core it may shut down. The CPU-stop request parks the stoppable CPU pairs with true high and complement low, and lets the free-running pairs continue.

Configuration bits from the register slave decide three things: whether each pair is stoppable, whether each pair is enabled, and whether parked CPU outputs are left driven or released to high impedance during power-down. The block turns these bits into per-pin drive enables.

Top module: `clk_stop_seq`

## Requirements
- R1: A low pulse on `pd_n` that covers at most one rising edge of the complement clock (a falling edge of `cpu_ph`) has no effect: `core_off` stays 0 and every output keeps toggling.
- R2: Once power-down is qualified, the outputs stop in order. `pcif_o` stops at its next low phase, and only after that does `buf_o` stop at its next low phase. The final falling edge of `pcif_o` therefore comes before the final falling edge of `buf_o`.
- R3: `core_off` (1 = core may shut down) rises only after every single-ended output is held low and every CPU true output is parked high. It returns to 0 after `pd_n` is released and the release is qualified.
- R4: In power-down, with `cfg_tri_pd` = 0 and `cfg_tri_force` = 0, each enabled pair drives `cpu_t` high (`cpu_t_oe` = 1) and leaves the complement undriven (`cpu_c_oe` = 0). An enable of 1 means driven.
- R5: In power-down with `cfg_tri_pd` = 1, both enables of every pair are 0.
- R6: In power-down with `cfg_tri_force` = 1, both enables of every pair are 0, even when `cfg_tri_pd` = 0.
- R7: While `cpustop_n` is low (after two complement-clock rising edges), each pair with `cfg_free[i]` = 0 holds `cpu_t[i]` = 1 and `cpu_c[i]` = 0 with both enables at 1. Each pair with `cfg_free[i]` = 1 keeps toggling.
- R8: After `cpustop_n` rises, a stopped pair toggles again within 16 sampling cycles, given a 4-cycle CPU phase and the default parameters.
- R9: `cfg_en[i]` = 0 forces `cpu_t_oe[i]` = 0 and `cpu_c_oe[i]` = 0 in every state.
- R10: No high or low time on any output is shorter than one half-period of its source phase. Outputs change gating state only at phase boundaries: single-ended outputs while their source is low, CPU pairs while `cpu_ph` is high.
- R11: If `pd_n` is released before the stop sequence finishes, the sequence still completes (`core_off` pulses high), after which the outputs restart in reverse order and run normally.
- R12: Out of reset `core_off` = 0 and all outputs are 0. While running, each output equals its source phase one sampling cycle later: `cpu_t` follows `cpu_ph`, and `cpu_c` follows its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpustop_n | input | 1 | Asynchronous active-low CPU stop request |
| cpu_ph | input | 1 | CPU source phase (true polarity) |
| pcif_ph | input | 1 | Free-running PCI source phase |
| buf_ph | input | 1 | 66 MHz buffer source phase |
| se_ph | input | NSE | Other single-ended source phases |
| cfg_free | input | NPAIR | 1 = pair keeps running during CPU stop |
| cfg_en | input | NPAIR | 1 = pair enabled |
| cfg_tri_pd | input | 1 | 1 = release all CPU pins in power-down |
| cfg_tri_force | input | 1 | 1 = release all CPU pins in power-down regardless of cfg_tri_pd |
| cpu_t | output | NPAIR | CPU true outputs |
| cpu_c | output | NPAIR | CPU complement outputs |
| cpu_t_oe | output | NPAIR | Drive enable of the true outputs |
| cpu_c_oe | output | NPAIR | Drive enable of the complement outputs |
| pcif_o | output | 1 | Gated free-running PCI output |
| buf_o | output | 1 | Gated buffer output |
| se_o | output | NSE | Other gated single-ended outputs |
| core_off | output | 1 | All clocks stopped; core may shut down |

## Verification
A running output reproduces its source one sampling cycle later. The bench therefore reads outputs at the falling clock edge and compares them with the source value that was present at the previous rising edge. A request becomes visible only after two synchroniser cycles plus two complement-clock rising edges. A stop or restart then completes at the next suitable phase boundary. For these results the bench waits a bounded number of cycles for a steady state, such as `core_off` rising or a toggle counter moving, and only then queues the expected values. Ordering and runt-free behaviour are judged from the cycle stamps of the final falling edges and from the shortest completed high or low run seen on each output group.

// File: rtl/clk_stop_seq.sv
module clk_stop_seq #(
  parameter int NSE         = 4,
  parameter int NPAIR       = 2,
  parameter int QUAL_EDGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             cpustop_n,
  input  logic             cpu_ph,
  input  logic             pcif_ph,
  input  logic             buf_ph,
  input  logic [NSE-1:0]   se_ph,
  input  logic [NPAIR-1:0] cfg_free,
  input  logic [NPAIR-1:0] cfg_en,
  input  logic             cfg_tri_pd,
  input  logic             cfg_tri_force,
  output logic [NPAIR-1:0] cpu_t,
  output logic [NPAIR-1:0] cpu_c,
  output logic [NPAIR-1:0] cpu_t_oe,
  output logic [NPAIR-1:0] cpu_c_oe,
  output logic             pcif_o,
  output logic             buf_o,
  output logic [NSE-1:0]   se_o,
  output logic             core_off
);

  localparam int            CW   = $clog2(QUAL_EDGES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_EDGES);

  typedef enum logic [2:0] {RUN, S_PCIF, S_BUF, S_REST, OFF, R_REST, R_BUF, R_PCIF} st_t;

  st_t                    st;
  logic [SYNC_STAGES-1:0] pd_sync, stp_sync;
  logic                   cpu_ph_d;
  logic [CW-1:0]          pd_cnt, stp_cnt;
  logic                   pcif_run, buf_run;
  logic [NSE-1:0]         se_run;
  logic [NPAIR-1:0]       cpd_run, cstp_run, cpu_go;
  logic                   pd_s, stp_s, crise, pd_q, stp_q, rest_down, rest_up;

  assign pd_s      = pd_sync[SYNC_STAGES-1];
  assign stp_s     = stp_sync[SYNC_STAGES-1];
  assign crise     = cpu_ph_d & ~cpu_ph;
  assign pd_q      = (pd_cnt == QMAX);
  assign stp_q     = (stp_cnt == QMAX);
  assign rest_down = (se_run == '0) && (cpd_run == '0);
  assign rest_up   = (&se_run) && (&cpd_run);
  assign cpu_go    = cpd_run & cstp_run;
  assign core_off  = (st == OFF);
  assign cpu_t_oe  = cfg_en & ~(~cpd_run & {NPAIR{cfg_tri_pd | cfg_tri_force}});
  assign cpu_c_oe  = cfg_en & cpd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_sync  <= '1;
      stp_sync <= '1;
      cpu_ph_d <= 1'b0;
      pd_cnt   <= '0;
      stp_cnt  <= '0;
    end else begin
      pd_sync  <= {pd_sync[SYNC_STAGES-2:0], pd_n};
      stp_sync <= {stp_sync[SYNC_STAGES-2:0], cpustop_n};
      cpu_ph_d <= cpu_ph;
      if (crise) begin
        pd_cnt  <= pd_s  ? '0 : (pd_q  ? pd_cnt  : pd_cnt  + 1'b1);
        stp_cnt <= stp_s ? '0 : (stp_q ? stp_cnt : stp_cnt + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RUN;
      pcif_run <= 1'b1;
      buf_run  <= 1'b1;
      se_run   <= '1;
      cpd_run  <= '1;
      cstp_run <= '1;
    end else begin
      case (st)
        RUN:    if (pd_q) st <= S_PCIF;
        S_PCIF: if (!pcif_ph) begin pcif_run <= 1'b0; st <= S_BUF; end
        S_BUF:  if (!buf_ph) begin buf_run <= 1'b0; st <= S_REST; end
        S_REST: if (rest_down) st <= OFF;
        OFF:    if (!pd_q) st <= R_REST;
        R_REST: if (rest_up) st <= R_BUF;
        R_BUF:  if (!buf_ph) begin buf_run <= 1'b1; st <= R_PCIF; end
        R_PCIF: if (!pcif_ph) begin pcif_run <= 1'b1; st <= RUN; end
        default: st <= RUN;
      endcase
      for (int k = 0; k < NSE; k++) begin
        if (!se_ph[k] && st == S_REST) se_run[k] <= 1'b0;
        else if (!se_ph[k] && st == R_REST) se_run[k] <= 1'b1;
      end
      for (int i = 0; i < NPAIR; i++) begin
        if (cpu_ph) begin
          if (st == S_REST) cpd_run[i] <= 1'b0;
          else if (st == R_REST) cpd_run[i] <= 1'b1;
          cstp_run[i] <= cfg_free[i] | ~stp_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcif_o <= 1'b0;
      buf_o  <= 1'b0;
      se_o   <= '0;
      cpu_t  <= '0;
      cpu_c  <= '0;
    end else begin
      pcif_o <= pcif_ph & pcif_run;
      buf_o  <= buf_ph & buf_run;
      se_o   <= se_ph & se_run;
      for (int i = 0; i < NPAIR; i++) begin
        cpu_t[i] <= cpu_go[i] ? cpu_ph : 1'b1;
        cpu_c[i] <= cpu_go[i] & ~cpu_ph;
      end
    end
  end

  // R3
  core_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_off |-> (!pcif_o && !buf_o && se_o == '0 && cpu_t == '1 && cpu_c == '0));

  // R4
  pd_park_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_off && !cfg_tri_pd && !cfg_tri_force) |-> (cpu_c_oe == '0 && cpu_t_oe == cfg_en));

  // R2
  stop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_run |-> !pcif_run);

  // R10
  pcif_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pcif_o) |-> !$past(pcif_ph));

  // R10
  buf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_o) |-> !$past(buf_ph));

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair_chk
    // R10
    cpu_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_t[g]) |-> !$past(cpu_ph));
  end

endmodule

// File: tb/clk_stop_seq_test.sv
`timescale 1ns/1ps
module clk_stop_seq_test;
  localparam int NSE = 4;
  localparam int NP  = 2;
  localparam int ID_ACT = 0, ID_COFF = 1, ID_PCIF = 2, ID_BUF = 3, ID_SE = 4,
                 ID_CT = 5, ID_CC = 6, ID_CTOE = 7, ID_CCOE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic pd_n = 1'b1, cpustop_n = 1'b1;
  logic [NP-1:0] cfg_free = 2'b10, cfg_en = 2'b11;
  logic cfg_tri_pd = 1'b0, cfg_tri_force = 1'b0;
  logic [2:0] ph_cnt = 3'd0;
  logic cpu_ph, pcif_ph, buf_ph, s0, s1;
  logic [NSE-1:0] se_ph;
  logic [NP-1:0] cpu_t, cpu_c, cpu_t_oe, cpu_c_oe;
  logic pcif_o, buf_o, core_off;
  logic [NSE-1:0] se_o;

  assign cpu_ph  = ~ph_cnt[1];
  assign pcif_ph = (ph_cnt < 3'd4);
  assign buf_ph  = (ph_cnt >= 3'd2) && (ph_cnt <= 3'd5);
  assign s0      = (ph_cnt >= 3'd4);
  assign s1      = (ph_cnt >= 3'd5) || (ph_cnt == 3'd0);
  assign se_ph   = {s1, s0, s1, s0};

  clk_stop_seq #(.NSE(NSE), .NPAIR(NP)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpustop_n(cpustop_n),
    .cpu_ph(cpu_ph), .pcif_ph(pcif_ph), .buf_ph(buf_ph), .se_ph(se_ph),
    .cfg_free(cfg_free), .cfg_en(cfg_en), .cfg_tri_pd(cfg_tri_pd), .cfg_tri_force(cfg_tri_force),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe),
    .pcif_o(pcif_o), .buf_o(buf_o), .se_o(se_o), .core_off(core_off));

  initial forever begin
    @(negedge clk);
    ph_cnt <= ph_cnt + 3'd1;
  end

  typedef struct {string req; int id; int act; int exp;} item_t;
  item_t sbq[$];
  int n_chk = 0, n_fail = 0;

  function automatic int obs(int id, int act);
    case (id)
      ID_COFF: return int'(core_off);
      ID_PCIF: return int'(pcif_o);
      ID_BUF:  return int'(buf_o);
      ID_SE:   return int'(se_o);
      ID_CT:   return int'(cpu_t);
      ID_CC:   return int'(cpu_c);
      ID_CTOE: return int'(cpu_t_oe);
      ID_CCOE: return int'(cpu_c_oe);
      default: return act;
    endcase
  endfunction

  task automatic expect_val(string req, int id, int act, int exp);
    sbq.push_back('{req, id, act, exp});
    @(posedge clk);
  endtask

  initial forever begin
    @(negedge clk);
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      int got;
      it = sbq.pop_front();
      got = obs(it.id, it.act);
      n_chk++;
      if (got != it.exp) begin
        n_fail++;
        $display("FAIL %s: signal %0d actual %0d expected %0d", it.req, it.id, got, it.exp);
      end
    end
  end

  int cyc = 0, pt_err = 0, min_se = 999, min_cpu = 999;
  int pcif_fall = -1, buf_fall = -1, t0_tog = 0, t1_tog = 0, pcif_tog = 0;
  bit pt_en = 0, meas_en = 0, coff_seen = 0;
  int se_len[NSE+2], cp_len[2*NP];
  bit se_valid[NSE+2], cp_valid[2*NP];
  logic [NSE+1:0] se_prev = '0;
  logic [2*NP-1:0] cp_prev = '0;

  initial forever begin
    logic [NSE+1:0] seb;
    logic [2*NP-1:0] cpb;
    @(negedge clk);
    cyc++;
    seb = {se_o, buf_o, pcif_o};
    cpb = {cpu_c, cpu_t};
    for (int b = 0; b < NSE + 2; b++) begin
      if (seb[b] != se_prev[b]) begin
        if (meas_en && se_valid[b] && se_len[b] < min_se) min_se = se_len[b];
        se_valid[b] = meas_en;
        se_len[b] = 1;
      end else se_len[b]++;
    end
    for (int b = 0; b < 2 * NP; b++) begin
      if (cpb[b] != cp_prev[b]) begin
        if (meas_en && cp_valid[b] && cp_len[b] < min_cpu) min_cpu = cp_len[b];
        cp_valid[b] = meas_en;
        cp_len[b] = 1;
      end else cp_len[b]++;
    end
    if (se_prev[0] && !pcif_o) pcif_fall = cyc;
    if (se_prev[1] && !buf_o) buf_fall = cyc;
    if (se_prev[0] != pcif_o) pcif_tog++;
    if (cp_prev[0] != cpu_t[0]) t0_tog++;
    if (cp_prev[1] != cpu_t[1]) t1_tog++;
    if (pt_en && (pcif_o != pcif_ph || buf_o != buf_ph || se_o != se_ph ||
                  cpu_t != {NP{cpu_ph}} || cpu_c != {NP{~cpu_ph}})) pt_err++;
    if (core_off) coff_seen = 1;
    se_prev = seb;
    cp_prev = cpb;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic pt_window(string req);
    pt_err = 0;
    pt_en = 1;
    repeat (40) @(negedge clk);
    pt_en = 0;
    expect_val(req, ID_ACT, pt_err, 0);
  endtask

  initial begin
    int lat, base;
    repeat (5) @(negedge clk);
    // R12 reset state
    expect_val("R12", ID_COFF, 0, 0);
    expect_val("R12", ID_PCIF, 0, 0);
    expect_val("R12", ID_CT, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    meas_en = 1;
    repeat (8) @(negedge clk);

    // R12 running pass-through
    pt_window("R12");
    expect_val("R12", ID_CTOE, 0, 3);
    expect_val("R12", ID_CCOE, 0, 3);

    // R1 short power-down pulse ignored
    @(negedge clk);
    coff_seen = 0;
    base = pcif_tog;
    pd_n = 1'b0;
    repeat (3) @(negedge clk);
    pd_n = 1'b1;
    repeat (30) @(negedge clk);
    expect_val("R1", ID_ACT, int'(coff_seen), 0);
    expect_val("R1", ID_ACT, int'(pcif_tog > base), 1);

    // R2 R3 R4 full power-down
    @(negedge clk);
    pcif_fall = -1;
    buf_fall = -1;
    pd_n = 1'b0;
    for (int i = 0; i < 200 && !core_off; i++) @(negedge clk);
    expect_val("R3", ID_COFF, 0, 1);
    expect_val("R2", ID_ACT, int'(pcif_fall >= 0 && pcif_fall < buf_fall), 1);
    expect_val("R3", ID_PCIF, 0, 0);
    expect_val("R3", ID_BUF, 0, 0);
    expect_val("R3", ID_SE, 0, 0);
    expect_val("R4", ID_CT, 0, 3);
    expect_val("R4", ID_CC, 0, 0);
    expect_val("R4", ID_CTOE, 0, 3);
    expect_val("R4", ID_CCOE, 0, 0);

    // R5 R6 release of CPU pins in power-down
    @(negedge clk);
    cfg_tri_pd = 1'b1;
    expect_val("R5", ID_CTOE, 0, 0);
    expect_val("R5", ID_CCOE, 0, 0);
    @(negedge clk);
    cfg_tri_pd = 1'b0;
    cfg_tri_force = 1'b1;
    expect_val("R6", ID_CTOE, 0, 0);
    expect_val("R6", ID_CCOE, 0, 0);
    @(negedge clk);
    cfg_tri_force = 1'b0;
    expect_val("R4", ID_CTOE, 0, 3);

    // R3 release and restart
    @(negedge clk);
    pd_n = 1'b1;
    for (int i = 0; i < 200 && core_off; i++) @(negedge clk);
    expect_val("R3", ID_COFF, 0, 0);
    repeat (40) @(negedge clk);
    pt_window("R12");

    // R7 CPU stop: pair 0 stoppable, pair 1 free
    @(negedge clk);
    cpustop_n = 1'b0;
    repeat (20) @(negedge clk);
    t0_tog = 0;
    t1_tog = 0;
    repeat (24) @(negedge clk);
    expect_val("R7", ID_ACT, t0_tog, 0);
    expect_val("R7", ID_ACT, int'(t1_tog > 0), 1);
    expect_val("R7", ID_ACT, int'(cpu_t[0]), 1);
    expect_val("R7", ID_ACT, int'(cpu_c[0]), 0);
    expect_val("R7", ID_CTOE, 0, 3);
    expect_val("R7", ID_CCOE, 0, 3);

    // R9 disabled pair
    @(negedge clk);
    cfg_en = 2'b01;
    expect_val("R9", ID_CTOE, 0, 1);
    expect_val("R9", ID_CCOE, 0, 1);
    @(negedge clk);
    cfg_en = 2'b11;

    // R8 restart latency
    @(negedge clk);
    cpustop_n = 1'b1;
    base = t0_tog;
    lat = 0;
    while (t0_tog == base && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    expect_val("R8", ID_ACT, int'(lat <= 16), 1);
    repeat (10) @(negedge clk);
    pt_window("R8");

    // R11 release during the stop sequence
    @(negedge clk);
    coff_seen = 0;
    pd_n = 1'b0;
    repeat (14) @(negedge clk);
    pd_n = 1'b1;
    repeat (100) @(negedge clk);
    expect_val("R11", ID_ACT, int'(coff_seen), 1);
    expect_val("R11", ID_COFF, 0, 0);
    pt_window("R11");

    // R10 no runt pulses
    expect_val("R10", ID_ACT, int'(min_se >= 4), 1);
    expect_val("R10", ID_ACT, int'(min_cpu >= 2), 1);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule